// File: doc/BRIEF.md
# Supply Power-Up Sequencer Controller

This block turns up to four supply channels on in a programmed time order when its run input rises, and turns them off in the opposite order when the run input falls. Each channel carries a small configuration code. The code places the channel in one of eight time slots, marks it unused, or marks it as a bench-test channel that is switched on while the controller is idle. Comparator results for each supply arrive as synchronous digital inputs:

- above the ramp-up threshold,
- above the undervoltage threshold,
- still above the ramp-down threshold.

Slots are visited in order. The gap between two occupied slots is one programmed step time. That gap is lengthened by however long the supplies of the current slot take to pass their ramp-up threshold. Slots with no channel in them cost no time.

A single watchdog measures the whole ramp, from the first switching action to the moment every supply has settled. When the watchdog runs out, all enables drop together and a sticky fault is raised. A busy flag is high while the ramp-up is in progress.

Top module: `supply_sequencer`

## Requirements
- R1: Each channel has a 4-bit code in `chan_cfg_i` (channel c at bits 4c+3..4c). Codes 1 to 8 place the channel in that slot. Code 15 marks it test-on. Codes 0 and 9 to 14 disable it, and such a channel is never enabled.
- R2: After reset, `done_o` and `fault_o` are low and `en_o` equals the set of test-on channels.
- R3: While idle, test-on channels are enabled. Once a ramp starts they are off, and they come back when the controller returns to idle.
- R4: The first occupied slot's channels are enabled `step_lim_i` cycles after the clock edge that samples `on_i` high. A step setting of 0 acts as 1.
- R5: Channels that share a slot are enabled on the same edge. The next occupied slot is enabled `step_lim_i` cycles after the edge on which every channel of the current slot shows `sup_up_i` high. Empty slots add no cycles.
- R6: `done_o` rises on the edge that samples `on_i` high. It falls one cycle after the last slot's channels pass their ramp-up threshold, provided every slotted channel then shows `sup_uv_i` high.
- R7: Ramp-down visits the occupied slots from highest to lowest. The first disable comes `step_lim_i` cycles after `on_i` is sampled low. Each later disable comes `step_lim_i` cycles after every channel of the previous slot shows `sup_dn_i` low.
- R8: The watchdog is armed on the first enable (or disable) of a ramp. If the ramp has not settled when the count reaches `pg_lim_i`, `fault_o` rises one cycle later and every enable drops on that same edge.
- R9: A `pg_lim_i` of 0 turns the watchdog off, and no fault is then raised however long a supply stalls.
- R10: `fault_o` stays high until `clr_i` is high while `on_i` is low. While the fault is held, `on_i` high starts no ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| on_i | input | 1 | Run request: high ramps up, low ramps down |
| clr_i | input | 1 | Fault clear, honoured only while `on_i` is low |
| chan_cfg_i | input | 16 | Four 4-bit channel codes |
| step_lim_i | input | 16 | Step time in cycles |
| pg_lim_i | input | 16 | Watchdog limit in cycles, 0 turns it off |
| sup_up_i | input | 4 | Supply above its ramp-up threshold |
| sup_uv_i | input | 4 | Supply above its undervoltage threshold |
| sup_dn_i | input | 4 | Supply still above its ramp-down threshold |
| en_o | output | 4 | Supply enables |
| done_o | output | 1 | Ramp-up in progress |
| fault_o | output | 1 | Sticky sequence fault |

## Verification
The bench sweeps channel codes, step settings and per-supply rise and fall delays. Its supply model answers the enables, and the expected edge of every enable and disable is worked out arithmetically. A design that charged cycles for empty slots, did not stretch a gap by the slowest supply in a slot, or walked the ramp-down upward would show enable or disable edges at the wrong cycle. A design that honoured the unused codes 9 to 14 would show a channel that should never switch on. A stalled supply is used to check that the watchdog trips on exactly the cycle the limit implies, that a limit of zero never trips, and that the fault holds against a clear pulse while the run input is high.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [3:0] {
      SQ_IDLE, SQ_UP_WAIT, SQ_UP_RISE, SQ_UP_SETTLE, SQ_HOLD,
      SQ_DN_WAIT, SQ_DN_FALL, SQ_DN_SETTLE, SQ_FAULT
   } sq_state_t;

   function automatic int code_width(input int npos);
      return $clog2(npos + 2);
   endfunction
endpackage

// File: rtl/seq_slot_map.sv
module seq_slot_map #(
   parameter int NCH  = 4,
   parameter int NPOS = 8,
   parameter int CW   = 4
) (
   input  logic [NCH*CW-1:0]          cfg_i,
   output logic [NPOS-1:0][NCH-1:0]   slot_o,
   output logic [NCH-1:0]             seq_o,
   output logic [NCH-1:0]             forced_o
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [CW-1:0]   code;
      logic [NPOS-1:0] col;
      assign code        = cfg_i[c*CW +: CW];
      assign forced_o[c] = (code == {CW{1'b1}});
      for (genvar p = 0; p < NPOS; p++) begin : g_pos
         assign col[p]       = (code == CW'(p + 1));
         assign slot_o[p][c] = col[p];
      end
      assign seq_o[c] = |col;
   end
endmodule

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic [TW-1:0] lim,
   output logic          hit
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt_q <= '0;
      else if (restart)         cnt_q <= '0;
      else if (cnt_q != '1)     cnt_q <= cnt_q + TW'(1);
   end

   assign hit = (lim == '0) || (cnt_q >= lim - TW'(1));

   assert_restart_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> cnt_q == '0);
endmodule

// File: rtl/seq_pg_watchdog.sv
module seq_pg_watchdog #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          arm,
   input  logic          clear,
   input  logic [TW-1:0] lim,
   output logic          expire
);
   logic          armed_q;
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (clear) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (arm) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (armed_q && cnt_q != '1) begin
         cnt_q <= cnt_q + TW'(1);
      end
   end

   assign expire = armed_q && (lim != '0) && (cnt_q == lim);

   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && lim != '0 && $stable(lim)) |-> cnt_q <= lim);
endmodule

// File: rtl/supply_sequencer.sv
module supply_sequencer #(
   parameter int NCH  = 4,
   parameter int NPOS = 8,
   parameter int TW   = 16,
   localparam int CW  = seq_pkg::code_width(NPOS),
   localparam int PW  = $clog2(NPOS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              on_i,
   input  logic              clr_i,
   input  logic [NCH*CW-1:0] chan_cfg_i,
   input  logic [TW-1:0]     step_lim_i,
   input  logic [TW-1:0]     pg_lim_i,
   input  logic [NCH-1:0]    sup_up_i,
   input  logic [NCH-1:0]    sup_uv_i,
   input  logic [NCH-1:0]    sup_dn_i,
   output logic [NCH-1:0]    en_o,
   output logic              done_o,
   output logic              fault_o
);
   import seq_pkg::*;

   if (NCH < 1)   begin : g_bad_nch  $error("NCH must be at least 1");  end
   if (NPOS < 2)  begin : g_bad_npos $error("NPOS must be at least 2"); end
   if (TW < 2)    begin : g_bad_tw   $error("TW must be at least 2");   end

   logic [NPOS-1:0][NCH-1:0] slot;
   logic [NCH-1:0]           seq_mask, forced_mask;
   logic [NPOS-1:0]          occ;

   seq_slot_map #(.NCH(NCH), .NPOS(NPOS), .CW(CW)) i_map (
      .cfg_i(chan_cfg_i), .slot_o(slot), .seq_o(seq_mask), .forced_o(forced_mask));

   for (genvar p = 0; p < NPOS; p++) begin : g_occ
      assign occ[p] = |slot[p];
   end

   sq_state_t       st_q, st_d;
   logic [PW-1:0]   ptr_q, ptr_d;
   logic [NCH-1:0]  en_q, en_d;
   logic            first_q, first_d;
   logic            step_restart, step_hit, wd_arm, wd_clear, wd_expire;

   seq_step_timer #(.TW(TW)) i_step (
      .clk(clk), .rst_n(rst_n), .restart(step_restart), .lim(step_lim_i), .hit(step_hit));

   seq_pg_watchdog #(.TW(TW)) i_wd (
      .clk(clk), .rst_n(rst_n), .arm(wd_arm), .clear(wd_clear), .lim(pg_lim_i),
      .expire(wd_expire));

   // lowest occupied slot at or above 'from'
   function automatic logic [PW:0] seek_up(input logic [NPOS-1:0] o, input logic [PW-1:0] from);
      logic          f  = 1'b0;
      logic [PW-1:0] ix = '0;
      for (int p = NPOS - 1; p >= 0; p--) begin
         if (o[p] && p >= int'(from)) begin
            f  = 1'b1;
            ix = PW'(p);
         end
      end
      return {f, ix};
   endfunction

   // highest occupied slot at or below 'from'
   function automatic logic [PW:0] seek_dn(input logic [NPOS-1:0] o, input logic [PW-1:0] from);
      logic          f  = 1'b0;
      logic [PW-1:0] ix = '0;
      for (int p = 0; p < NPOS; p++) begin
         if (o[p] && p <= int'(from)) begin
            f  = 1'b1;
            ix = PW'(p);
         end
      end
      return {f, ix};
   endfunction

   logic [PW:0]    up_hit, dn_hit, up_next, dn_next;
   logic           more_up, more_dn;
   logic [NCH-1:0] cur_mask;

   assign up_hit   = seek_up(occ, ptr_q);
   assign dn_hit   = seek_dn(occ, ptr_q);
   assign up_next  = seek_up(occ, ptr_q + PW'(1));
   assign dn_next  = seek_dn(occ, ptr_q - PW'(1));
   assign more_up  = (ptr_q != PW'(NPOS - 1)) && up_next[PW];
   assign more_dn  = (ptr_q != '0) && dn_next[PW];
   assign cur_mask = slot[ptr_q];

   always_comb begin
      st_d         = st_q;
      ptr_d        = ptr_q;
      en_d         = en_q;
      first_d      = first_q;
      step_restart = 1'b0;
      wd_arm       = 1'b0;
      wd_clear     = 1'b0;
      unique case (st_q)
         SQ_IDLE: begin
            en_d     = '0;
            wd_clear = 1'b1;
            if (on_i) begin
               st_d         = SQ_UP_WAIT;
               ptr_d        = '0;
               step_restart = 1'b1;
               first_d      = 1'b1;
            end
         end
         SQ_UP_WAIT, SQ_UP_RISE, SQ_UP_SETTLE: begin
            if (!on_i) begin
               st_d         = SQ_DN_WAIT;
               ptr_d        = PW'(NPOS - 1);
               step_restart = 1'b1;
               first_d      = 1'b1;
               wd_clear     = 1'b1;
            end else if (st_q == SQ_UP_WAIT) begin
               if (step_hit) begin
                  if (up_hit[PW]) begin
                     en_d  = en_q | slot[up_hit[PW-1:0]];
                     ptr_d = up_hit[PW-1:0];
                     st_d  = SQ_UP_RISE;
                     if (first_q) begin
                        wd_arm  = 1'b1;
                        first_d = 1'b0;
                     end
                  end else begin
                     st_d = SQ_UP_SETTLE;
                  end
               end
            end else if (st_q == SQ_UP_RISE) begin
               if ((sup_up_i & cur_mask) == cur_mask) begin
                  if (more_up) begin
                     ptr_d        = ptr_q + PW'(1);
                     step_restart = 1'b1;
                     st_d         = SQ_UP_WAIT;
                  end else begin
                     st_d = SQ_UP_SETTLE;
                  end
               end
            end else begin
               if ((sup_uv_i & seq_mask) == seq_mask) begin
                  st_d     = SQ_HOLD;
                  wd_clear = 1'b1;
               end
            end
         end
         SQ_HOLD: begin
            if (!on_i) begin
               st_d         = SQ_DN_WAIT;
               ptr_d        = PW'(NPOS - 1);
               step_restart = 1'b1;
               first_d      = 1'b1;
               wd_clear     = 1'b1;
            end
         end
         SQ_DN_WAIT: begin
            if (step_hit) begin
               if (dn_hit[PW]) begin
                  en_d  = en_q & ~slot[dn_hit[PW-1:0]];
                  ptr_d = dn_hit[PW-1:0];
                  st_d  = SQ_DN_FALL;
                  if (first_q) begin
                     wd_arm  = 1'b1;
                     first_d = 1'b0;
                  end
               end else begin
                  st_d = SQ_DN_SETTLE;
               end
            end
         end
         SQ_DN_FALL: begin
            if ((sup_dn_i & cur_mask) == '0) begin
               if (more_dn) begin
                  ptr_d        = ptr_q - PW'(1);
                  step_restart = 1'b1;
                  st_d         = SQ_DN_WAIT;
               end else begin
                  st_d = SQ_DN_SETTLE;
               end
            end
         end
         SQ_DN_SETTLE: begin
            if ((sup_dn_i & seq_mask) == '0) begin
               st_d     = SQ_IDLE;
               wd_clear = 1'b1;
            end
         end
         SQ_FAULT: begin
            en_d     = '0;
            wd_clear = 1'b1;
            if (!on_i && clr_i) st_d = SQ_IDLE;
         end
         default: st_d = SQ_IDLE;
      endcase
      if (wd_expire && st_q != SQ_IDLE && st_q != SQ_HOLD && st_q != SQ_FAULT) begin
         st_d     = SQ_FAULT;
         en_d     = '0;
         wd_clear = 1'b1;
         wd_arm   = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         ptr_q   <= '0;
         en_q    <= '0;
         first_q <= 1'b0;
      end else begin
         st_q    <= st_d;
         ptr_q   <= ptr_d;
         en_q    <= en_d;
         first_q <= first_d;
      end
   end

   assign en_o    = (st_q == SQ_IDLE) ? forced_mask : en_q;
   assign done_o  = (st_q == SQ_UP_WAIT) || (st_q == SQ_UP_RISE) || (st_q == SQ_UP_SETTLE);
   assign fault_o = (st_q == SQ_FAULT);

   assert_dead_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (en_o & ~(seq_mask | forced_mask)) == '0);
   assert_up_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && $past(done_o)) |-> ((en_o & $past(en_o)) == $past(en_o)));
   assert_done_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> $past(on_i));
   assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o |-> en_o == '0);
   assert_pg_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o) |-> $past(pg_lim_i) != '0);
   assert_fault_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !(!on_i && clr_i)) |=> fault_o);
endmodule

// File: tb/test_supply_sequencer.sv
module test_supply_sequencer;
   localparam int NCH = 4;
   localparam int TW  = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            on_i = 1'b0, clr_i = 1'b0;
   logic [15:0]     chan_cfg_i = '0;
   logic [TW-1:0]   step_lim_i = 16'd1, pg_lim_i = 16'd100;
   logic [NCH-1:0]  sup_up_b = '0, live_b = '0;
   logic [NCH-1:0]  en_o;
   logic            done_o, fault_o;

   int total = 0, bad = 0, ncyc = 0;
   bit finished = 0;
   int cfg_b [NCH], rr [NCH], ff [NCH];
   int onage [NCH], offage [NCH], rise_t [NCH], fall_t [NCH];
   int exp_rise [NCH], exp_fall [NCH];
   int done_rise_t, done_fall_t;

   always #5 clk = ~clk;

   supply_sequencer i_supply_sequencer (
      .clk(clk), .rst_n(rst_n), .on_i(on_i), .clr_i(clr_i), .chan_cfg_i(chan_cfg_i),
      .step_lim_i(step_lim_i), .pg_lim_i(pg_lim_i), .sup_up_i(sup_up_b),
      .sup_uv_i(sup_up_b), .sup_dn_i(live_b), .en_o(en_o), .done_o(done_o),
      .fault_o(fault_o));

   always @(posedge clk) ncyc <= ncyc + 1;

   // supply model and edge recorder, updated away from the active edge
   always @(negedge clk) begin
      for (int i = 0; i < NCH; i++) begin
         if (en_o[i]) begin onage[i]++; offage[i] = 0; end
         else begin offage[i]++; onage[i] = 0; end
         sup_up_b[i] = en_o[i] && (onage[i] >= rr[i]);
         if (sup_up_b[i]) live_b[i] = 1'b1;
         else if (!en_o[i] && offage[i] >= ff[i]) live_b[i] = 1'b0;
         if (en_o[i] && rise_t[i] < 0) rise_t[i] = ncyc;
         if (!en_o[i] && rise_t[i] >= 0 && fall_t[i] < 0) fall_t[i] = ncyc;
      end
      if (done_o && done_rise_t < 0) done_rise_t = ncyc;
      if (!done_o && done_rise_t >= 0 && done_fall_t < 0) done_fall_t = ncyc;
   end

   task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic clear_rec();
      for (int i = 0; i < NCH; i++) begin rise_t[i] = -1; fall_t[i] = -1; end
      done_rise_t = -1;
      done_fall_t = -1;
   endtask

   task automatic load_cfg();
      for (int i = 0; i < NCH; i++) chan_cfg_i[i*4 +: 4] = 4'(cfg_b[i]);
   endtask

   function automatic logic [NCH-1:0] forced_set();
      logic [NCH-1:0] m = '0;
      for (int i = 0; i < NCH; i++) m[i] = (cfg_b[i] == 15);
      return m;
   endfunction

   initial begin
      for (int i = 0; i < NCH; i++) begin
         onage[i] = 0; offage[i] = 0; rr[i] = 1; ff[i] = 1; cfg_b[i] = 0;
      end
      clear_rec();
      // reset state with a test-on channel present (R2)
      cfg_b[0] = 3; cfg_b[1] = 15; cfg_b[2] = 0; cfg_b[3] = 15;
      load_cfg();
      tick(3);
      rst_n = 1'b1;
      tick(1);
      chk(done_o == 1'b0 && fault_o == 1'b0, "R2 flags after reset", {done_o, fault_o}, 0);
      chk(en_o == 4'b1010, "R2 enables after reset", en_o, 4'b1010);

      // sweep of codes, steps and supply delays
      for (int t = 0; t < 12; t++) begin
         int step, eff, P, Q, tm, last, rmax, any;
         bit hit;
         step = t % 4;
         eff  = (step == 0) ? 1 : step;
         for (int i = 0; i < NCH; i++) begin
            int v;
            v = (t*7 + i*3 + t*i) % 11;
            cfg_b[i] = (v == 0) ? 0 : (v <= 8) ? v : (v == 9) ? 15 : 12;
            rr[i] = 1 + (t + i) % 3;
            ff[i] = 1 + (t*2 + i) % 3;
            exp_rise[i] = -1;
            exp_fall[i] = -1;
         end
         load_cfg();
         step_lim_i = 16'(step);
         pg_lim_i   = 16'd100;
         tick(4);
         chk(en_o == forced_set(), "R3 test-on enabled while idle", en_o, forced_set());
         clear_rec();
         P = ncyc;
         on_i = 1'b1;
         // expected ramp-up edges (R4, R5, R6)
         tm = P + 1 + eff; any = 0; last = 0;
         for (int p = 1; p <= 8; p++) begin
            rmax = 0; hit = 0;
            for (int i = 0; i < NCH; i++)
               if (cfg_b[i] == p) begin
                  exp_rise[i] = tm; hit = 1;
                  if (rr[i] > rmax) rmax = rr[i];
               end
            if (hit) begin last = tm + rmax; tm = tm + rmax + eff; any = 1; end
         end
         for (int k = 0; k < 300 && done_fall_t < 0; k++) tick(1);
         tick(3);
         for (int i = 0; i < NCH; i++) begin
            if (cfg_b[i] >= 1 && cfg_b[i] <= 8)
               chk(rise_t[i] == exp_rise[i], "R4 R5 enable edge", rise_t[i], exp_rise[i]);
            else if (cfg_b[i] == 15)
               chk(en_o[i] == 1'b0, "R3 test-on off during ramp", en_o[i], 0);
            else
               chk(rise_t[i] == -1, "R1 disabled code never enabled", rise_t[i], -1);
         end
         chk(done_rise_t == P + 1, "R6 busy rises", done_rise_t, P + 1);
         chk(done_fall_t == (any ? last + 1 : P + 2 + eff), "R6 busy falls",
             done_fall_t, any ? last + 1 : P + 2 + eff);
         // ramp-down (R7)
         Q = ncyc;
         on_i = 1'b0;
         tm = Q + 1 + eff;
         for (int p = 8; p >= 1; p--) begin
            rmax = 0; hit = 0;
            for (int i = 0; i < NCH; i++)
               if (cfg_b[i] == p) begin
                  exp_fall[i] = tm; hit = 1;
                  if (ff[i] > rmax) rmax = ff[i];
               end
            if (hit) tm = tm + rmax + eff;
         end
         tick(tm - ncyc + 4);
         for (int i = 0; i < NCH; i++)
            if (cfg_b[i] >= 1 && cfg_b[i] <= 8)
               chk(fall_t[i] == exp_fall[i], "R7 disable edge", fall_t[i], exp_fall[i]);
         chk(en_o == forced_set() && fault_o == 1'b0, "R3 back to idle", en_o, forced_set());
      end

      // stalled supply trips the watchdog (R8)
      cfg_b[0] = 1; cfg_b[1] = 2; cfg_b[2] = 0; cfg_b[3] = 15;
      rr[0] = 100000; rr[1] = 1; rr[2] = 1; rr[3] = 1;
      load_cfg();
      step_lim_i = 16'd2;
      pg_lim_i   = 16'd10;
      tick(4);
      begin
         int P;
         P = ncyc;
         on_i = 1'b1;
         tick(3);
         chk(en_o == 4'b0001, "R4 first slot before stall", en_o, 4'b0001);
         tick(10);
         chk(fault_o == 1'b0, "R8 no fault before limit", fault_o, 0);
         tick(1);
         chk(fault_o == 1'b1, "R8 fault at limit", fault_o, 1);
         chk(en_o == 4'b0000, "R8 enables dropped", en_o, 0);
         clr_i = 1'b1;
         tick(1);
         clr_i = 1'b0;
         tick(5);
         chk(fault_o == 1'b1, "R10 clear ignored while run high", fault_o, 1);
         chk(en_o == 4'b0000, "R10 no ramp while fault held", en_o, 0);
         on_i = 1'b0;
         tick(3);
         chk(fault_o == 1'b1, "R10 held without clear", fault_o, 1);
         clr_i = 1'b1;
         tick(1);
         clr_i = 1'b0;
         chk(fault_o == 1'b0, "R10 cleared", fault_o, 0);
         chk(en_o == 4'b1000, "R10 idle after clear", en_o, 4'b1000);
         if (P < 0) $display("unreachable");
      end

      // watchdog switched off (R9)
      pg_lim_i = 16'd0;
      tick(2);
      on_i = 1'b1;
      tick(200);
      chk(fault_o == 1'b0, "R9 no fault with limit zero", fault_o, 0);
      chk(en_o == 4'b0001, "R9 stalled ramp holds", en_o, 4'b0001);
      on_i = 1'b0;
      tick(10);
      chk(en_o == 4'b1000 && fault_o == 1'b0, "R9 ramp-down completes", en_o, 4'b1000);

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule